// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier Core

This block multiplies two binary floating-point operands and hands an unrounded result to a separate rounding stage. Each operand word carries a sign at its top bit, then a biased exponent field, then a fraction field. The bias is 2^(EXP_W-1)-1, which is 127 at the default widths of an 8-bit exponent and a 23-bit fraction. The core splits both operands, puts back the hidden leading one, and forms the full double-width product of the two significands. It adds the exponents less one bias and shifts the product so that exactly one integer bit remains. The result is the sign, a signed pre-rounding exponent, the kept significand, and guard, round and sticky bits for the rounder.

Special operands take a separate path. Zero, infinity, quiet NaN and signaling NaN are recognised on both inputs. For these the core emits a finished special result marked by `out_special`, so the rounder can pass it through unchanged. It also raises invalid, signaling-NaN, quiet-NaN, zero-result and infinity-result flags. A subnormal input, meaning an exponent field of zero, is handled as a signed zero.

Operands enter on a valid/ready stream and results leave on another, through one register stage. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so there is no bubble under steady flow. While `out_valid` is high and `out_ready` is low, the result and all flags hold still and no new pair is taken.

Top module: `fmul_core`

## Requirements
- R1: An operand is treated as zero when its exponent field is 0. It is infinity when the exponent field is all ones and the fraction is 0. It is a quiet NaN when the exponent field is all ones and the fraction MSB is 1. It is a signaling NaN when the exponent field is all ones, the fraction MSB is 0 and the fraction is nonzero. Every other operand is a normal number with significand {1, fraction}.
- R2: The result sign `out_sign` is the XOR of the two operand sign bits, for every operand pair including the special ones.
- R3: When both operands are normal, `out_exp` is the signed (EXP_W+2)-bit value ea + eb - bias. It is one larger when the significand product is 2 or more, meaning the top product bit is set.
- R4: When both operands are normal, `out_sig` holds the FRAC_W+1 product bits that start at the leading one, so its MSB is 1. `out_guard` is the next lower product bit and `out_round` is the one below that. `out_sticky` is the OR of all remaining lower product bits.
- R5: When either operand is a NaN, or one operand is zero and the other is infinity, the result is special with exponent all ones, `out_sig` = 2'b11 followed by zeros (quiet NaN), guard/round/sticky 0, and `out_invalid` = 1.
- R6: `out_snan` is 1 when either operand is a signaling NaN. `out_qnan` is 1 for every other invalid case. A signaling-NaN pattern (fraction MSB 0) is never produced.
- R7: When one operand is infinity and the other is normal or infinity, the result is special with exponent all ones, `out_sig` = 1 followed by zeros, `out_inf` = 1, and no invalid flag. No exponent overflow is reported for it.
- R8: When one operand is zero and the other is normal or zero, the result is a signed special zero with exponent 0, `out_sig` = 0, and `out_zero` = 1.
- R9: `out_zero` and `out_inf` are set exactly when the result is zero or infinity. At most one of `out_zero`, `out_inf`, `out_invalid` is set. `out_special` is 0 only for a normal-by-normal product.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted pair appears on the outputs with `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Core can take a pair this cycle |
| in_a | input | EXP_W+FRAC_W+1 | First operand word |
| in_b | input | EXP_W+FRAC_W+1 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W+2 | Signed pre-rounding exponent |
| out_sig | output | FRAC_W+1 | Normalized significand, leading one at MSB |
| out_guard | output | 1 | First bit below the kept significand |
| out_round | output | 1 | Second bit below the kept significand |
| out_sticky | output | 1 | OR of all lower product bits |
| out_special | output | 1 | Result is a finished special value |
| out_invalid | output | 1 | Invalid operation |
| out_snan | output | 1 | Signaling NaN operand seen |
| out_qnan | output | 1 | Invalid without a signaling NaN operand |
| out_zero | output | 1 | Result is zero |
| out_inf | output | 1 | Result is infinity |

## Verification
The bench builds the core with a 4-bit exponent and a 3-bit fraction, which gives 8-bit operand words. That makes every one of the 65,536 operand pairs reachable in a single streamed sweep at one pair per clock. The sweep covers every pairing of zero, subnormal, normal, infinity, quiet NaN and signaling NaN. It also covers the product both below and above 2, and every guard, round and sticky combination the 4-bit significands can form. A separate stalled transfer holds `out_ready` low to show the result holding still and the next pair waiting at the input.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  // Operand classes recognised by the unpack stage
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_NORM,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } op_class_e;

  function automatic logic is_nan(input op_class_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig,
  output fmul_pkg::op_class_e   cls
);
  import fmul_pkg::*;

  logic [FRAC_W-1:0] frac;

  assign sign  = word[EXP_W+FRAC_W];
  assign exp_f = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac  = word[FRAC_W-1:0];
  assign sig   = {1'b1, frac};

  always_comb begin
    if (exp_f == '0)                cls = CLS_ZERO;
    else if (exp_f != '1)           cls = CLS_NORM;
    else if (frac == '0)            cls = CLS_INF;
    else if (frac[FRAC_W-1])        cls = CLS_QNAN;
    else                            cls = CLS_SNAN;
  end
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W:0]          sig_a,
  input  logic [FRAC_W:0]          sig_b,
  input  logic [EXP_W-1:0]         exp_a,
  input  logic [EXP_W-1:0]         exp_b,
  output logic signed [EXP_W+1:0]  exp_o,
  output logic [FRAC_W:0]          sig_o,
  output logic                     guard_o,
  output logic                     round_o,
  output logic                     sticky_o
);
  localparam int SW   = FRAC_W + 1;
  localparam int PW   = 2 * SW;
  localparam int XW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [PW-1:0] prod;
  logic [PW-1:0] aligned;
  logic          two_int;

  assign prod    = sig_a * sig_b;
  assign two_int = prod[PW-1];
  // Single left shift when the product is below 2
  assign aligned = two_int ? prod : {prod[PW-2:0], 1'b0};

  assign sig_o    = aligned[PW-1:SW];
  assign guard_o  = aligned[SW-1];
  assign round_o  = aligned[SW-2];
  assign sticky_o = |aligned[SW-3:0];

  assign exp_o = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
               - $signed(XW'(BIAS)) + $signed({{(XW-1){1'b0}}, two_int});
endmodule

// File: rtl/fmul_special.sv
module fmul_special #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  fmul_pkg::op_class_e      cls_a,
  input  fmul_pkg::op_class_e      cls_b,
  output logic                     special,
  output logic                     invalid,
  output logic                     snan,
  output logic                     qnan,
  output logic                     zero,
  output logic                     inf,
  output logic signed [EXP_W+1:0]  sp_exp,
  output logic [FRAC_W:0]          sp_sig
);
  import fmul_pkg::*;

  logic any_nan, zero_inf, any_zero, any_inf;

  assign any_nan  = is_nan(cls_a) || is_nan(cls_b);
  assign any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
  assign any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
  assign zero_inf = any_zero && any_inf;

  assign invalid = any_nan || zero_inf;
  assign snan    = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  assign qnan    = invalid && !snan;
  assign inf     = !invalid && any_inf;
  assign zero    = !invalid && any_zero;
  assign special = invalid || inf || zero;

  always_comb begin
    sp_exp = $signed({2'b00, {EXP_W{1'b1}}});
    sp_sig = '0;
    if (invalid)   sp_sig = {2'b11, {(FRAC_W-1){1'b0}}};
    else if (inf)  sp_sig = {1'b1, {FRAC_W{1'b0}}};
    else if (zero) sp_exp = '0;
  end
endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [EXP_W+FRAC_W:0]    in_a,
  input  logic [EXP_W+FRAC_W:0]    in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_sign,
  output logic signed [EXP_W+1:0]  out_exp,
  output logic [FRAC_W:0]          out_sig,
  output logic                     out_guard,
  output logic                     out_round,
  output logic                     out_sticky,
  output logic                     out_special,
  output logic                     out_invalid,
  output logic                     out_snan,
  output logic                     out_qnan,
  output logic                     out_zero,
  output logic                     out_inf
);
  import fmul_pkg::*;

  localparam int WW = EXP_W + FRAC_W + 1;
  localparam int SW = FRAC_W + 1;
  localparam int XW = EXP_W + 2;

  logic [1:0][WW-1:0]    op_word;
  logic [1:0]            op_sign;
  logic [1:0][EXP_W-1:0] op_exp;
  logic [1:0][SW-1:0]    op_sig;
  op_class_e             op_cls [2];

  assign op_word[0] = in_a;
  assign op_word[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .word  (op_word[i]),
      .sign  (op_sign[i]),
      .exp_f (op_exp[i]),
      .sig   (op_sig[i]),
      .cls   (op_cls[i])
    );
  end

  logic signed [XW-1:0] n_exp, s_exp;
  logic [SW-1:0]        n_sig, s_sig;
  logic                 n_g, n_r, n_s;
  logic                 s_spec, s_inv, s_snan, s_qnan, s_zero, s_inf;

  fmul_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul (
    .sig_a    (op_sig[0]),
    .sig_b    (op_sig[1]),
    .exp_a    (op_exp[0]),
    .exp_b    (op_exp[1]),
    .exp_o    (n_exp),
    .sig_o    (n_sig),
    .guard_o  (n_g),
    .round_o  (n_r),
    .sticky_o (n_s)
  );

  fmul_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spc (
    .cls_a   (op_cls[0]),
    .cls_b   (op_cls[1]),
    .special (s_spec),
    .invalid (s_inv),
    .snan    (s_snan),
    .qnan    (s_qnan),
    .zero    (s_zero),
    .inf     (s_inf),
    .sp_exp  (s_exp),
    .sp_sig  (s_sig)
  );

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_sig     <= '0;
      out_guard   <= 1'b0;
      out_round   <= 1'b0;
      out_sticky  <= 1'b0;
      out_special <= 1'b0;
      out_invalid <= 1'b0;
      out_snan    <= 1'b0;
      out_qnan    <= 1'b0;
      out_zero    <= 1'b0;
      out_inf     <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_sign    <= op_sign[0] ^ op_sign[1];
        out_exp     <= s_spec ? s_exp : n_exp;
        out_sig     <= s_spec ? s_sig : n_sig;
        out_guard   <= !s_spec && n_g;
        out_round   <= !s_spec && n_r;
        out_sticky  <= !s_spec && n_s;
        out_special <= s_spec;
        out_invalid <= s_inv;
        out_snan    <= s_snan;
        out_qnan    <= s_qnan;
        out_zero    <= s_zero;
        out_inf     <= s_inf;
      end
    end
  end

  // R10: a stalled result holds every field
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_sign, out_exp, out_sig,
      out_guard, out_round, out_sticky, out_special, out_invalid, out_snan,
      out_qnan, out_zero, out_inf})));

  // R10: an accepted pair is presented on the next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4: a non-special result leaves with its leading one at the MSB
  p_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_special) |-> out_sig[SW-1]);

  // R9: result classes are exclusive
  p_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_zero, out_inf, out_invalid}));

  // R9: every exception class marks the result special
  p_spec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_zero || out_inf || out_invalid)) |-> out_special);

  // R6: the invalid cause is exactly one of the two NaN kinds
  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_snan, out_qnan}) == (out_invalid ? 1 : 0)));

  // R5: an invalid result is a quiet NaN with no rounding bits
  p_qnan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_sig[SW-1:SW-2] == 2'b11 &&
      out_exp[EXP_W-1:0] == '1 && !out_guard && !out_round && !out_sticky));

  // R11: nothing is presented straight out of reset
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/sim_fmul_core.sv
module sim_fmul_core;
  localparam int E    = 4;
  localparam int F    = 3;
  localparam int WW   = E + F + 1;
  localparam int S    = F + 1;
  localparam int BIAS = (1 << (E - 1)) - 1;
  localparam int EMAX = (1 << E) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [WW-1:0] in_a = '0;
  logic [WW-1:0] in_b = '0;
  logic in_ready, out_valid, out_sign, out_guard, out_round, out_sticky;
  logic out_special, out_invalid, out_snan, out_qnan, out_zero, out_inf;
  logic signed [E+1:0] out_exp;
  logic [F:0] out_sig;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fmul_core #(.EXP_W(E), .FRAC_W(F)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
    .out_guard(out_guard), .out_round(out_round), .out_sticky(out_sticky),
    .out_special(out_special), .out_invalid(out_invalid), .out_snan(out_snan),
    .out_qnan(out_qnan), .out_zero(out_zero), .out_inf(out_inf)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // class codes: 0 zero, 1 normal, 2 inf, 3 qnan, 4 snan (R1)
  function automatic int classify(input int w);
    int e = (w >> F) & EMAX;
    int f = w & ((1 << F) - 1);
    if (e == 0) return 0;
    if (e != EMAX) return 1;
    if (f == 0) return 2;
    if (f >= (1 << (F - 1))) return 3;
    return 4;
  endfunction

  task automatic check_out(input int a, input int b);
    int ca = classify(a);
    int cb = classify(b);
    bit nan = (ca >= 3) || (cb >= 3);
    bit zi  = ((ca == 0) || (cb == 0)) && ((ca == 2) || (cb == 2));
    bit inv = nan || zi;
    bit sn  = (ca == 4) || (cb == 4);
    bit isf = !inv && ((ca == 2) || (cb == 2));
    bit isz = !inv && ((ca == 0) || (cb == 0));
    chk("R10 out_valid", int'(out_valid), 1);
    chk("R2 sign", int'(out_sign), ((a >> (WW - 1)) ^ (b >> (WW - 1))) & 1);
    chk("R6 snan/qnan", {out_snan, out_qnan}, {sn, inv && !sn});
    chk("R9 zero/inf", {out_zero, out_inf}, {isz, isf});
    if (inv) begin
      chk("R5 qnan result", {out_special, out_invalid, int'(out_exp), int'(out_sig),
          out_guard, out_round, out_sticky},
          {1'b1, 1'b1, EMAX, (3 << (F - 1)), 3'b000});
    end else if (isf) begin
      chk("R7 inf result", {out_special, out_invalid, int'(out_exp), int'(out_sig),
          out_guard, out_round, out_sticky},
          {1'b1, 1'b0, EMAX, (1 << F), 3'b000});
    end else if (isz) begin
      chk("R8 zero result", {out_special, out_invalid, int'(out_exp), int'(out_sig),
          out_guard, out_round, out_sticky},
          {1'b1, 1'b0, 0, 0, 3'b000});
    end else begin
      int ea = (a >> F) & EMAX;
      int eb = (b >> F) & EMAX;
      int ma = (1 << F) | (a & ((1 << F) - 1));
      int mb = (1 << F) | (b & ((1 << F) - 1));
      int p  = ma * mb;
      int sh = (p >= (1 << (2 * S - 1))) ? S : S - 1;
      int ex = ea + eb - BIAS + ((sh == S) ? 1 : 0);
      int g  = (p >> (sh - 1)) & 1;
      int r  = (p >> (sh - 2)) & 1;
      int st = ((p & ((1 << (sh - 2)) - 1)) != 0) ? 1 : 0;
      chk("R9 special low", int'(out_special), 0);
      chk("R3 exponent", int'(out_exp), ex);
      chk("R4 sig/grs", {int'(out_sig), out_guard, out_round, out_sticky},
          {p >> sh, g[0], r[0], st[0]});
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pa = 0;
    int pb = 0;
    bit have = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", int'(out_valid), 0);
    chk("R11 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // full streamed sweep, one pair per cycle
    for (int a = 0; a < (1 << WW); a++) begin
      for (int b = 0; b < (1 << WW); b++) begin
        @(negedge clk);
        if (have) check_out(pa, pb);
        in_a = WW'(a); in_b = WW'(b); in_valid = 1'b1;
        pa = a; pb = b; have = 1'b1;
      end
    end
    @(negedge clk);
    check_out(pa, pb);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", int'(out_valid), 0);

    // stall: 1.5*1.5 held, then 2*(-inf) queued (R10)
    in_a = 8'h3C; in_b = 8'h3C; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R10 in_ready low while stalled", int'(in_ready), 0);
    in_a = 8'h40; in_b = 8'hF8;
    @(negedge clk);
    @(negedge clk);
    check_out(8'h3C, 8'h3C);
    out_ready = 1'b1;
    @(negedge clk);
    check_out(8'h40, 8'hF8);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule